// File: doc/BRIEF.md
# Pixel Format Packer

This block sits at the write end of a display pipeline. It takes one 8-bit-per-channel pixel per handshake (alpha, red, green and blue from the top byte down) and turns it into the byte layout that a 4-bit format code selects. The converted bytes go into a little-endian byte stream. The stream is cut into 32-bit words, and each word carries a 4-bit byte strobe. Pixels of 2, 3 or 4 bytes are packed with no gaps, so a 3-byte pixel can straddle two words.

An end-of-line marker on the input closes the current line. Any bytes left over are sent as a final partial word, and that word is marked end-of-line. Alpha can be passed through, inverted, or replaced by a constant. A 4-lane mask clears the store strobe of chosen byte lanes in every word. The configuration inputs are quasi-static: they are changed only while the block holds no line in progress.

Top module: `pix_format_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Codes 12, 13, 14 and 15 give the 32-bit values {A,B,G,R}, {A,R,G,B}, {B,G,R,A} and {R,G,B,A}, with the first-listed channel in the most significant byte. Each value is stored least significant byte first, and stream byte k of a word goes to lane k (bits 8k+7:8k).
- R3: Codes 0, 1, 2 and 3 give 16-bit values with the same four channel orders as R2, built from the upper 4 bits of each channel.
- R4: Code 6 gives the 16-bit value {B[7:3],G[7:2],R[7:3]}, and code 7 gives {R[7:3],G[7:2],B[7:3]}.
- R5: Code 8 gives the 3-byte value {B,G,R}, and code 9 gives {R,G,B}. Pixels pack back to back, so four pixels fill exactly three words.
- R6: With `alpha_keep`=1, the stored alpha is the input alpha, bitwise inverted when `alpha_flip`=1. With `alpha_keep`=0, the stored alpha is 8'hFF when `alpha_flip`=0 and 8'h00 when `alpha_flip`=1.
- R7: The strobe bit of lane i in every output word is 0 whenever `lane_mask[i]` is 0. The word data is unaffected.
- R8: A full word has strobe equal to `lane_mask`. When a line ends with n leftover bytes (n from 1 to 3), one more word is sent. That word has those bytes in the low lanes, zeros above them, strobe equal to the low n lanes AND `lane_mask`, and `out_eol`=1. If the line ends exactly on a word boundary, that last full word carries `out_eol`=1.
- R9: Codes 4, 5, 10 and 11 produce no output words, but their pixels are still accepted.
- R10: While `out_valid`=1 and `out_ready`=0, the output word, strobe and end marker hold steady. No pixel byte is lost or duplicated under any backpressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_code | input | 4 | Output layout code |
| alpha_keep | input | 1 | Store input alpha (1) or a constant (0) |
| alpha_flip | input | 1 | Invert stored alpha, or choose the constant 8'h00 |
| lane_mask | input | 4 | Per-lane store enable |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | 32 | {A,R,G,B} input pixel |
| in_eol | input | 1 | Pixel is the last of its line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 32 | Packed data word |
| out_strb | output | 4 | Byte store strobes |
| out_eol | output | 1 | Word ends a line |

## Verification
The assertions assume that `fmt_code`, `alpha_keep`, `alpha_flip` and `lane_mask` do not change while a line is partly packed or a word is still waiting at the output. The stimulus changes them only after every expected word of the previous line has been collected. The assertions also assume that a pixel offered on `in_valid` stays in place until it is accepted. The bench therefore holds each offered pixel until the handshake completes, while both `in_valid` and `out_ready` are toggled at random to exercise stalls.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int CH_W     = 8;
  localparam int LANES    = 4;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = LANES * BYTE_W;
  localparam int ACC_W    = (LANES - 1) * BYTE_W;
  localparam int COMB_W   = WORD_W + ACC_W;
  localparam int CNT_W    = 3;
  localparam int FILL_W   = 2;

  localparam logic [3:0] F_ABGR4444 = 4'd0;
  localparam logic [3:0] F_ARGB4444 = 4'd1;
  localparam logic [3:0] F_BGRA4444 = 4'd2;
  localparam logic [3:0] F_RGBA4444 = 4'd3;
  localparam logic [3:0] F_BGR565   = 4'd6;
  localparam logic [3:0] F_RGB565   = 4'd7;
  localparam logic [3:0] F_BGR888   = 4'd8;
  localparam logic [3:0] F_RGB888   = 4'd9;
  localparam logic [3:0] F_ABGR8888 = 4'd12;
  localparam logic [3:0] F_ARGB8888 = 4'd13;
  localparam logic [3:0] F_BGRA8888 = 4'd14;
  localparam logic [3:0] F_RGBA8888 = 4'd15;

  function automatic logic [LANES-1:0] low_lanes(input logic [CNT_W-1:0] n);
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(n)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic is_unsupported(input logic [3:0] code);
    return (code == 4'd4) || (code == 4'd5) || (code == 4'd10) || (code == 4'd11);
  endfunction
endpackage

// File: rtl/pfp_pixel_map.sv
module pfp_pixel_map
  import pfp_pkg::*;
(
  input  logic [3:0]             fmt_code,
  input  logic                   alpha_keep,
  input  logic                   alpha_flip,
  input  logic [4*CH_W-1:0]      pixel,
  output logic [WORD_W-1:0]      packed_val,
  output logic [CNT_W-1:0]       packed_n
);
  logic [CH_W-1:0] ch_a, ch_r, ch_g, ch_b, a_eff;
  logic [3:0]      a4, r4, g4, b4;
  logic [4:0]      r5, b5;
  logic [5:0]      g6;

  assign ch_a = pixel[4*CH_W-1:3*CH_W];
  assign ch_r = pixel[3*CH_W-1:2*CH_W];
  assign ch_g = pixel[2*CH_W-1:CH_W];
  assign ch_b = pixel[CH_W-1:0];

  always_comb begin
    if (alpha_keep) a_eff = alpha_flip ? ~ch_a : ch_a;
    else            a_eff = alpha_flip ? '0 : '1;
  end

  assign a4 = a_eff[CH_W-1 -: 4];
  assign r4 = ch_r[CH_W-1 -: 4];
  assign g4 = ch_g[CH_W-1 -: 4];
  assign b4 = ch_b[CH_W-1 -: 4];
  assign r5 = ch_r[CH_W-1 -: 5];
  assign g6 = ch_g[CH_W-1 -: 6];
  assign b5 = ch_b[CH_W-1 -: 5];

  always_comb begin
    packed_val = '0;
    packed_n   = '0;
    case (fmt_code)
      F_ABGR4444: begin packed_val[15:0] = {a4, b4, g4, r4}; packed_n = 3'd2; end
      F_ARGB4444: begin packed_val[15:0] = {a4, r4, g4, b4}; packed_n = 3'd2; end
      F_BGRA4444: begin packed_val[15:0] = {b4, g4, r4, a4}; packed_n = 3'd2; end
      F_RGBA4444: begin packed_val[15:0] = {r4, g4, b4, a4}; packed_n = 3'd2; end
      F_BGR565:   begin packed_val[15:0] = {b5, g6, r5};     packed_n = 3'd2; end
      F_RGB565:   begin packed_val[15:0] = {r5, g6, b5};     packed_n = 3'd2; end
      F_BGR888:   begin packed_val[23:0] = {ch_b, ch_g, ch_r}; packed_n = 3'd3; end
      F_RGB888:   begin packed_val[23:0] = {ch_r, ch_g, ch_b}; packed_n = 3'd3; end
      F_ABGR8888: begin packed_val = {a_eff, ch_b, ch_g, ch_r}; packed_n = 3'd4; end
      F_ARGB8888: begin packed_val = {a_eff, ch_r, ch_g, ch_b}; packed_n = 3'd4; end
      F_BGRA8888: begin packed_val = {ch_b, ch_g, ch_r, a_eff}; packed_n = 3'd4; end
      F_RGBA8888: begin packed_val = {ch_r, ch_g, ch_b, a_eff}; packed_n = 3'd4; end
      default:    begin packed_val = '0; packed_n = '0; end
    endcase
  end
endmodule

// File: rtl/pfp_byte_pack.sv
module pfp_byte_pack
  import pfp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_mask,
  input  logic               pix_take,
  input  logic [WORD_W-1:0]  pix_val,
  input  logic [CNT_W-1:0]   pix_n,
  input  logic               pix_eol,
  output logic               take_ok,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word,
  output logic [LANES-1:0]   out_strb,
  output logic               out_eol
);
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              flush_q, flush_d;
  logic              ov_q, ov_d;
  logic [WORD_W-1:0] ow_q, ow_d;
  logic [LANES-1:0]  os_q, os_d;
  logic              oe_q, oe_d;
  logic              load_ok;
  logic [COMB_W-1:0] comb;
  logic [3:0]        total;
  logic [3:0]        rem;
  logic              en;

  assign load_ok = !ov_q || out_ready;
  assign take_ok = load_ok && !flush_q;
  assign comb    = {{WORD_W{1'b0}}, acc_q} | ({{ACC_W{1'b0}}, pix_val} << {fill_q, 3'b000});
  assign total   = {2'b00, fill_q} + {1'b0, pix_n};
  assign rem     = total - 4'd4;
  assign en      = load_ok || pix_take;

  always_comb begin
    acc_d   = acc_q;
    fill_d  = fill_q;
    flush_d = flush_q;
    ov_d    = ov_q && !out_ready;
    ow_d    = ow_q;
    os_d    = os_q;
    oe_d    = oe_q;
    if (flush_q && load_ok) begin
      ov_d    = 1'b1;
      ow_d    = {{BYTE_W{1'b0}}, acc_q};
      os_d    = low_lanes({1'b0, fill_q}) & lane_mask;
      oe_d    = 1'b1;
      acc_d   = '0;
      fill_d  = '0;
      flush_d = 1'b0;
    end else if (pix_take) begin
      if (total >= 4'd4) begin
        ov_d    = 1'b1;
        ow_d    = comb[WORD_W-1:0];
        os_d    = lane_mask;
        acc_d   = comb[COMB_W-1:WORD_W];
        fill_d  = rem[FILL_W-1:0];
        oe_d    = pix_eol && (rem == 4'd0);
        flush_d = pix_eol && (rem != 4'd0);
      end else begin
        acc_d  = comb[ACC_W-1:0];
        fill_d = total[FILL_W-1:0];
        if (pix_eol && (total != 4'd0)) begin
          ov_d   = 1'b1;
          ow_d   = comb[WORD_W-1:0];
          os_d   = low_lanes(total[CNT_W-1:0]) & lane_mask;
          oe_d   = 1'b1;
          acc_d  = '0;
          fill_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      fill_q  <= '0;
      flush_q <= 1'b0;
      ov_q    <= 1'b0;
      ow_q    <= '0;
      os_q    <= '0;
      oe_q    <= 1'b0;
    end else if (en) begin
      acc_q   <= acc_d;
      fill_q  <= fill_d;
      flush_q <= flush_d;
      ov_q    <= ov_d;
      ow_q    <= ow_d;
      os_q    <= os_d;
      oe_q    <= oe_d;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;
  assign out_strb  = os_q;
  assign out_eol   = oe_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(ow_q) && $stable(os_q) && $stable(oe_q)));

  assert_lane_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> ((os_q & ~lane_mask) == '0));

  assert_full_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !oe_q) |-> (os_q == lane_mask));

  assert_flush_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && load_ok) |=> (ov_q && oe_q && !flush_q));
endmodule

// File: rtl/pix_format_packer.sv
module pix_format_packer
  import pfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fmt_code,
  input  logic              alpha_keep,
  input  logic              alpha_flip,
  input  logic [3:0]        lane_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_pixel,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_word,
  output logic [3:0]        out_strb,
  output logic              out_eol
);
  logic [WORD_W-1:0] map_val;
  logic [CNT_W-1:0]  map_n;
  logic              take_ok;
  logic              pix_take;

  pfp_pixel_map map_i (
    .fmt_code   (fmt_code),
    .alpha_keep (alpha_keep),
    .alpha_flip (alpha_flip),
    .pixel      (in_pixel),
    .packed_val (map_val),
    .packed_n   (map_n)
  );

  assign pix_take = in_valid && take_ok;
  assign in_ready = take_ok;

  pfp_byte_pack pack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_mask (lane_mask),
    .pix_take  (pix_take),
    .pix_val   (map_val),
    .pix_n     (map_n),
    .pix_eol   (in_eol),
    .take_ok   (take_ok),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_strb  (out_strb),
    .out_eol   (out_eol)
  );

  assert_unsupported_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && is_unsupported(fmt_code) && !out_valid) |=> !out_valid);
endmodule

// File: tb/pix_format_packer_tb_top.sv
`timescale 1ns/1ps
module pix_format_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  fmt_code;
  logic        alpha_keep, alpha_flip;
  logic [3:0]  lane_mask;
  logic        in_valid, in_ready, in_eol;
  logic [31:0] in_pixel;
  logic        out_valid, out_ready, out_eol;
  logic [31:0] out_word;
  logic [3:0]  out_strb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pix_format_packer dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .alpha_keep(alpha_keep),
    .alpha_flip(alpha_flip), .lane_mask(lane_mask), .in_valid(in_valid),
    .in_ready(in_ready), .in_pixel(in_pixel), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_strb(out_strb), .out_eol(out_eol)
  );

  function automatic int bytes_of(input int f);
    case (f)
      0, 1, 2, 3, 6, 7: return 2;
      8, 9:             return 3;
      12, 13, 14, 15:   return 4;
      default:          return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_value(input int f, input bit keep, input bit flip,
                                            input logic [31:0] px);
    logic [7:0] a, r, g, b;
    r = px[23:16]; g = px[15:8]; b = px[7:0];
    if (keep) a = flip ? ~px[31:24] : px[31:24];
    else      a = flip ? 8'h00 : 8'hFF;
    case (f)
      0:  return {16'h0, a[7:4], b[7:4], g[7:4], r[7:4]};
      1:  return {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]};
      2:  return {16'h0, b[7:4], g[7:4], r[7:4], a[7:4]};
      3:  return {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]};
      6:  return {16'h0, b[7:3], g[7:2], r[7:3]};
      7:  return {16'h0, r[7:3], g[7:2], b[7:3]};
      8:  return {8'h0, b, g, r};
      9:  return {8'h0, r, g, b};
      12: return {a, b, g, r};
      13: return {a, r, g, b};
      14: return {b, g, r, a};
      15: return {r, g, b, a};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_line(input int f, input bit keep, input bit flip, input logic [3:0] mask,
                          input int npix, input bit dir, input logic [31:0] base, input string tag);
    logic [31:0] pix[$];
    logic [7:0]  bq[$];
    logic [31:0] ew[$];
    logic [3:0]  es[$];
    bit          ee[$];
    int pi, got, nb;
    bit stall_seen;
    logic [31:0] stall_word;
    @(negedge clk);
    fmt_code = f[3:0]; alpha_keep = keep; alpha_flip = flip; lane_mask = mask;
    for (int i = 0; i < npix; i++) pix.push_back(dir ? base + i * 32'h01020304 : $urandom);
    nb = bytes_of(f);
    for (int i = 0; i < npix; i++) begin
      logic [31:0] v;
      v = ref_value(f, keep, flip, pix[i]);
      for (int k = 0; k < nb; k++) bq.push_back(v[8*k +: 8]);
    end
    for (int s = 0; s < bq.size(); s += 4) begin
      logic [31:0] w;
      int cnt;
      w = '0; cnt = 0;
      for (int k = 0; k < 4 && s + k < bq.size(); k++) begin
        w[8*k +: 8] = bq[s+k];
        cnt++;
      end
      ew.push_back(w);
      es.push_back(((4'hF >> (4 - cnt)) & mask));
      ee.push_back(s + 4 >= bq.size());
    end
    pi = 0; got = 0; stall_seen = 0; stall_word = '0;
    in_valid = 0;
    while (pi < npix || got < ew.size()) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (!in_valid && pi < npix && ($urandom % 4) != 0) begin
        in_valid = 1; in_pixel = pix[pi]; in_eol = (pi == npix - 1);
      end
      #1;
      if (stall_seen) begin
        check(out_valid && out_word == stall_word, "R10", "stalled word", out_word, stall_word);
        stall_seen = 0;
      end
      if (in_valid && in_ready) begin
        pi++;
      end
      if (out_valid && out_ready) begin
        if (got < ew.size()) begin
          check(out_word == ew[got], tag, "word", out_word, ew[got]);
          check(out_strb == es[got], "R7", "strobe", out_strb, es[got]);
          check(out_eol == ee[got], "R8", "eol", out_eol, ee[got]);
        end else begin
          check(0, tag, "extra word", out_word, 0);
        end
        got++;
      end else if (out_valid) begin
        stall_seen = 1; stall_word = out_word;
      end
      @(posedge clk);
      #1;
      if (in_valid && pi > 0 && in_pixel == pix[pi-1] && !(pi < npix && in_pixel == pix[pi])) begin
        in_valid = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    if (ew.size() == 0) begin
      repeat (6) begin
        @(negedge clk);
        #1;
        check(!out_valid, "R9", "no output for unsupported code", out_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int codes[10] = '{0, 1, 2, 3, 6, 7, 8, 9, 12, 13};
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; in_pixel = '0; in_eol = 0; out_ready = 0;
    fmt_code = 4'd13; alpha_keep = 1; alpha_flip = 0; lane_mask = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    run_line(13, 1, 0, 4'hF, 2, 1, 32'h11223344, "R2");
    run_line(12, 1, 0, 4'hF, 3, 1, 32'hA1B2C3D4, "R2");
    run_line(14, 1, 1, 4'hF, 2, 1, 32'h55667788, "R6");
    run_line(15, 0, 0, 4'hF, 2, 1, 32'h00102030, "R6");
    run_line(15, 0, 1, 4'hF, 2, 1, 32'h80102030, "R6");
    run_line(1, 1, 0, 4'hF, 3, 1, 32'hF0E0D0C0, "R3");
    run_line(2, 0, 0, 4'hF, 4, 1, 32'h12345678, "R3");
    run_line(7, 1, 0, 4'hF, 3, 1, 32'hFFFF0000, "R4");
    run_line(6, 1, 0, 4'hF, 1, 1, 32'h00FF8001, "R4");
    run_line(9, 1, 0, 4'hF, 4, 1, 32'h00112233, "R5");
    run_line(8, 1, 0, 4'hF, 5, 1, 32'h00ABCDEF, "R5");
    run_line(9, 1, 0, 4'hF, 6, 1, 32'h00010203, "R8");
    run_line(13, 1, 0, 4'h5, 3, 1, 32'hDEADBEEF, "R7");
    run_line(9, 1, 0, 4'hA, 5, 1, 32'h00C0FFEE, "R7");
    run_line(4, 1, 0, 4'hF, 3, 1, 32'h01010101, "R9");
    run_line(5, 1, 0, 4'hF, 2, 1, 32'h02020202, "R9");
    run_line(10, 1, 0, 4'hF, 2, 1, 32'h03030303, "R9");
    run_line(11, 1, 0, 4'hF, 2, 1, 32'h04040404, "R9");
    run_line(13, 1, 0, 4'hF, 2, 1, 32'h0A0B0C0D, "R9");

    for (int n = 0; n < 80; n++) begin
      int f;
      f = ($urandom % 8 == 0) ? 14 + ($urandom % 2) : codes[$urandom % 10];
      run_line(f, $urandom % 2, $urandom % 2,
               ($urandom % 4 == 0) ? 4'($urandom) : 4'hF,
               1 + ($urandom % 9), 0, 32'h0, "R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule